// File: doc/BRIEF.md
# PS/2 Scancode Sequence Decoder

This block sits after a PS/2 keyboard byte receiver. The receiver checks the serial framing and hands over bytes. Each byte arrives with a one-cycle strobe, an 8-bit value and an error flag. A keyboard reports one key action as a short run of bytes, and this block folds that run into a single key event.

Two prefix values can come before an ordinary code. The release marker (0xF0) says that the key is being let go. The extension marker (0xE0) says that the key belongs to the later, extended set. The decoder keeps both markers as pending flags and applies them to the next ordinary code. It then produces one registered event that carries the raw code and two flags. The prefix bytes themselves produce no event. A byte that the receiver flags as faulty is dropped, and it wipes any pending markers.

The event fields stay stable between events, so a consumer can sample them at any time. The event strobe lasts exactly one clock.

Top module: `ps2_seq_decoder`

## Requirements
- R1: While the synchronous active-low reset is low, both pending markers are cleared and the outputs read evt_valid=0, evt_code=0x00, evt_release=0 and evt_ext=0.
- R2: An accepted byte that is neither 0xE0 nor 0xF0, with no marker pending, produces evt_valid=1 on the clock after the strobe. It carries evt_release=0 and evt_ext=0, and both markers are clear afterwards.
- R3: The sequence 0xF0 then a code produces one event with evt_release=1 and evt_ext=0.
- R4: The sequence 0xE0 then a code produces one event with evt_ext=1 and evt_release=0.
- R5: The sequence 0xE0, 0xF0, code produces one event with evt_ext=1 and evt_release=1.
- R6: An accepted 0xE0 or 0xF0 byte never raises evt_valid on the following clock.
- R7: A strobed byte with in_err=1 produces no event and clears both pending markers. The next code therefore yields evt_release=0 and evt_ext=0.
- R8: A second 0xE0 while the extension marker is pending leaves the marker set and produces no event. The next code gives a single event with evt_ext=1.
- R9: evt_valid is high for exactly one clock per event. evt_code, evt_release and evt_ext keep their values until the next event.
- R10: Bytes strobed on consecutive clock cycles are each processed, giving one event per code byte in arrival order.
- R11: evt_code equals the strobed code byte bit for bit, with no character mapping, for every value other than the two marker values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | One-cycle strobe: a received byte is present |
| in_code | input | 8 | Received byte value |
| in_err | input | 1 | Receiver reports a framing or parity fault for this byte |
| evt_valid | output | 1 | One-cycle key event strobe |
| evt_code | output | 8 | Raw key code of the last event |
| evt_release | output | 1 | Last event was a key release |
| evt_ext | output | 1 | Last event was an extended key |

## Verification
The bench builds the decoder with its default parameters: an 8-bit code, 0xE0 as the extension marker and 0xF0 as the release marker. At these settings the byte space is small enough to sweep every non-marker value through the press path, which covers R11 completely. The fixed marker values also let directed sequences cover each marker ordering: doubled markers, error bytes between a marker and its code, and back-to-back strobes with no idle cycle between them.

// File: rtl/ps2_seq_pkg.sv
// Package: shared types for the scancode sequence decoder.
// Assumes an 8-bit PS/2 byte unless CODE_W is changed at the top level.
package ps2_seq_pkg;

    // Pending marker state carried between bytes.
    typedef struct packed {
        logic ext;
        logic brk;
    } pend_t;

    // Kind of an accepted byte, as decided by the classifier.
    typedef enum logic [1:0] {
        BK_CODE = 2'd0,
        BK_EXT  = 2'd1,
        BK_BRK  = 2'd2
    } byte_kind_e;

endpackage

// File: rtl/ps2_seq_classify.sv
// Module: ps2_seq_classify
// Sorts one byte into extension marker, release marker or ordinary code.
// Purely combinational; it assumes the two marker values differ.
module ps2_seq_classify
    import ps2_seq_pkg::*;
#(
    parameter int              CODE_W   = 8,
    parameter logic [CODE_W-1:0] EXT_MARK = 8'hE0,
    parameter logic [CODE_W-1:0] BRK_MARK = 8'hF0
) (
    input  logic [CODE_W-1:0] code,
    output byte_kind_e        kind
);

    // Compare the byte against both marker values.
    always_comb begin
        if (code == EXT_MARK)      kind = BK_EXT;
        else if (code == BRK_MARK) kind = BK_BRK;
        else                       kind = BK_CODE;
    end

endmodule

// File: rtl/ps2_seq_prefix.sv
// Module: ps2_seq_prefix
// Holds the pending extension and release markers between bytes.
// Assumes take is a one-cycle strobe; an errored byte wipes both markers,
// and an ordinary code consumes them.
module ps2_seq_prefix
    import ps2_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       err,
    input  byte_kind_e kind,
    output pend_t      pend
);

    pend_t pend_q;

    // Update the markers on each strobed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (take) begin
            if (err) begin
                pend_q <= '0;
            end else begin
                unique case (kind)
                    BK_EXT:  pend_q.ext <= 1'b1;
                    BK_BRK:  pend_q.brk <= 1'b1;
                    default: pend_q     <= '0;
                endcase
            end
        end
    end

    assign pend = pend_q;

    // An errored byte leaves no marker behind.
    p_err_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && err) |=> (pend_q == '0));

    // A repeated extension marker keeps the extended state.
    p_ext_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !err && kind == BK_EXT) |=> pend_q.ext);

    // An ordinary code consumes both markers.
    p_code_consumes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !err && kind == BK_CODE) |=> (pend_q == '0));

endmodule

// File: rtl/ps2_seq_event.sv
// Module: ps2_seq_event
// Registers one key event when an error-free ordinary code arrives.
// Assumes pend carries the markers seen before this byte. The fields hold
// between events and the strobe lasts one cycle.
module ps2_seq_event
    import ps2_seq_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              err,
    input  byte_kind_e        kind,
    input  logic [CODE_W-1:0] code,
    input  pend_t             pend,
    output logic              ev_valid,
    output logic [CODE_W-1:0] ev_code,
    output logic              ev_release,
    output logic              ev_ext
);

    logic fire;

    // An event fires only for a clean, ordinary byte.
    always_comb fire = take && !err && (kind == BK_CODE);

    // Capture the event fields and form the one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_valid   <= 1'b0;
            ev_code    <= '0;
            ev_release <= 1'b0;
            ev_ext     <= 1'b0;
        end else begin
            ev_valid <= fire;
            if (fire) begin
                ev_code    <= code;
                ev_release <= pend.brk;
                ev_ext     <= pend.ext;
            end
        end
    end

    // Marker bytes never raise the strobe.
    p_prefix_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !err && kind != BK_CODE) |=> !ev_valid);

    // Between events the fields do not move.
    p_hold_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |-> ($stable(ev_code) && $stable(ev_release) && $stable(ev_ext)));

    // The event code is the raw byte that triggered it.
    p_code_raw_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (ev_code == $past(code)));

    // The release flag reflects the marker pending before the code byte.
    p_release_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (ev_release == $past(pend.brk)));

endmodule

// File: rtl/ps2_seq_decoder.sv
// Module: ps2_seq_decoder (top)
// Folds PS/2 release (0xF0) and extension (0xE0) marker bytes into flags on
// the following code byte and emits one registered key event per code.
// Assumes in_valid is a one-cycle strobe from a byte receiver that flags
// framing and parity faults on in_err.
module ps2_seq_decoder
    import ps2_seq_pkg::*;
#(
    parameter int                CODE_W   = 8,
    parameter logic [CODE_W-1:0] EXT_MARK = 8'hE0,
    parameter logic [CODE_W-1:0] BRK_MARK = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_code,
    input  logic              in_err,
    output logic              evt_valid,
    output logic [CODE_W-1:0] evt_code,
    output logic              evt_release,
    output logic              evt_ext
);

    byte_kind_e kind;
    pend_t      pend;

    ps2_seq_classify #(
        .CODE_W   (CODE_W),
        .EXT_MARK (EXT_MARK),
        .BRK_MARK (BRK_MARK)
    ) u_classify (
        .code (in_code),
        .kind (kind)
    );

    ps2_seq_prefix u_prefix (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (in_valid),
        .err   (in_err),
        .kind  (kind),
        .pend  (pend)
    );

    ps2_seq_event #(
        .CODE_W (CODE_W)
    ) u_event (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (in_valid),
        .err        (in_err),
        .kind       (kind),
        .code       (in_code),
        .pend       (pend),
        .ev_valid   (evt_valid),
        .ev_code    (evt_code),
        .ev_release (evt_release),
        .ev_ext     (evt_ext)
    );

    // Every event traces back to a clean strobe on the previous cycle.
    p_event_needs_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(in_valid && !in_err));

    // An errored byte never produces an event.
    p_err_no_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_err) |=> !evt_valid);

endmodule

// File: tb/ps2_seq_decoder_bench.sv
// Directed bench for ps2_seq_decoder: one task per scenario.
module ps2_seq_decoder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_code = 8'h00;
    logic       in_err = 1'b0;
    logic       evt_valid;
    logic [7:0] evt_code;
    logic       evt_release;
    logic       evt_ext;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ps2_seq_decoder u_ps2_seq_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_code     (in_code),
        .in_err      (in_err),
        .evt_valid   (evt_valid),
        .evt_code    (evt_code),
        .evt_release (evt_release),
        .evt_ext     (evt_ext)
    );

    // Compare {valid, release, ext, code} against the expected value.
    task automatic chk(string req, logic v, logic rel, logic ext, logic [7:0] c);
        logic [10:0] act, exp;
        act = {evt_valid, evt_release, evt_ext, evt_code};
        exp = {v, rel, ext, c};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual v/rel/ext/code=%b/%b/%b/%h expected %b/%b/%b/%h",
                     req, act[10], act[9], act[8], act[7:0], v, rel, ext, c);
        end
    endtask

    // Strobe one byte for a cycle; returns at the negedge after it was taken.
    task automatic send(logic [7:0] b, logic e);
        @(negedge clk);
        in_valid = 1'b1;
        in_code  = b;
        in_err   = e;
        @(negedge clk);
        in_valid = 1'b0;
        in_err   = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", 1'b0, 1'b0, 1'b0, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset release", 1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_press;
        send(8'h1C, 1'b0);
        chk("R2 plain press", 1'b1, 1'b0, 1'b0, 8'h1C);
        @(negedge clk);
        chk("R9 strobe drops, fields hold", 1'b0, 1'b0, 1'b0, 8'h1C);
    endtask

    task automatic t_release;
        send(8'hF0, 1'b0);
        chk("R6 release marker silent", 1'b0, 1'b0, 1'b0, 8'h1C);
        send(8'h1C, 1'b0);
        chk("R3 release event", 1'b1, 1'b1, 1'b0, 8'h1C);
        send(8'h32, 1'b0);
        chk("R2 markers consumed", 1'b1, 1'b0, 1'b0, 8'h32);
    endtask

    task automatic t_ext;
        send(8'hE0, 1'b0);
        chk("R6 extension marker silent", 1'b0, 1'b0, 1'b0, 8'h32);
        send(8'h75, 1'b0);
        chk("R4 extended press", 1'b1, 1'b0, 1'b1, 8'h75);
    endtask

    task automatic t_ext_release;
        send(8'hE0, 1'b0);
        send(8'hF0, 1'b0);
        chk("R6 two markers silent", 1'b0, 1'b0, 1'b1, 8'h75);
        send(8'h6B, 1'b0);
        chk("R5 extended release", 1'b1, 1'b1, 1'b1, 8'h6B);
    endtask

    task automatic t_err;
        send(8'hE0, 1'b0);
        send(8'hF0, 1'b0);
        send(8'h44, 1'b1);
        chk("R7 errored byte no event", 1'b0, 1'b1, 1'b1, 8'h6B);
        send(8'h44, 1'b0);
        chk("R7 markers cleared by error", 1'b1, 1'b0, 1'b0, 8'h44);
    endtask

    task automatic t_double_ext;
        send(8'hE0, 1'b0);
        send(8'hE0, 1'b0);
        chk("R8 second E0 silent", 1'b0, 1'b0, 1'b0, 8'h44);
        send(8'h11, 1'b0);
        chk("R8 single extended event", 1'b1, 1'b0, 1'b1, 8'h11);
        @(negedge clk);
        chk("R8 no second event", 1'b0, 1'b0, 1'b1, 8'h11);
    endtask

    task automatic t_hold;
        send(8'hF0, 1'b0);
        send(8'h2A, 1'b0);
        repeat (5) @(negedge clk);
        chk("R9 fields held over idle", 1'b0, 1'b1, 1'b0, 8'h2A);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        in_valid = 1'b1; in_code = 8'h15;
        @(negedge clk);
        chk("R10 first of back-to-back", 1'b1, 1'b0, 1'b0, 8'h15);
        in_code = 8'hF0;
        @(negedge clk);
        chk("R10 marker in stream", 1'b0, 1'b0, 1'b0, 8'h15);
        in_code = 8'h15;
        @(negedge clk);
        chk("R10 release in stream", 1'b1, 1'b1, 1'b0, 8'h15);
        in_code = 8'h24;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 last of back-to-back", 1'b1, 1'b0, 1'b0, 8'h24);
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 256; i++) begin
            if (i != 8'hE0 && i != 8'hF0) begin
                send(8'(i), 1'b0);
                chk("R11 raw code sweep", 1'b1, 1'b0, 1'b0, 8'(i));
            end
        end
    endtask

    initial begin
        t_reset();
        t_press();
        t_release();
        t_ext();
        t_ext_release();
        t_err();
        t_double_ext();
        t_hold();
        t_back_to_back();
        t_sweep();
        t_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule